// File: doc/BRIEF.md
# Configurable Output Cell for a Programmable Logic Array

This block is the output stage that follows the sum-of-products array of a small programmable logic device. Each cell takes one OR-summed term and produces a pin value, a pin drive enable and a feedback value that returns to the array. Two configuration bits per cell set its behaviour. One bit selects either a D flip-flop clocked by the global clock or a direct combinatorial path. The other bit selects whether the pin is active-high or active-low.

The flip-flops share several global controls:

- An asynchronous clear.
- A power-up initialisation input that has the same clearing effect.
- A synchronous preset.
- A preload path, so that a test can place any value in the registers.

The parameter `CELLS` sets how many cells sit side by side. The cells share the global controls, and each cell keeps its own configuration.

Top module: `pld_out_cell`

## Requirements
- R1: With its mode bit low (combinatorial), a cell's pin value follows its sum input in the same cycle, with no clock edge needed.
- R2: With its polarity bit high, the pin carries the selected source unchanged. With the polarity bit low, the pin carries the inverse of the source.
- R3: While `areset` is high, every register reads 0 at once, with no clock edge needed. A registered active-high pin then shows 0 and a registered active-low pin shows 1.
- R4: While `pwr_init` is high, the registers are cleared in the same way as for `areset`.
- R5: With its mode bit high (registered), a cell's register takes its sum input on the rising clock edge. The pin does not change before that edge.
- R6: When `spreset` is high, every register is set to 1 on the next rising edge, and not before that edge.
- R7: When `preload_en` is high, the registers load `preload_val` on the next rising edge. Preload takes priority over both preset and the sum inputs.
- R8: When the clear (`areset` or `pwr_init`) is active together with preset or preload, the registers stay at 0.
- R9: `pin_en` follows the cell's `oe` term. The pin value is still computed while the drive is off.
- R10: In registered mode, feedback is the register's true output whatever the polarity. In combinatorial mode, feedback equals the pin value.
- R11: Each cell follows its own mode and polarity bits, independently of its neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock |
| pwr_init | input | 1 | Power-up initialisation; clears the registers asynchronously |
| areset | input | 1 | Global asynchronous clear term |
| spreset | input | 1 | Global synchronous preset term |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | CELLS | Value loaded into the registers by preload |
| sum | input | CELLS | OR-sum of each cell's product terms |
| reg_mode | input | CELLS | 1 = registered, 0 = combinatorial |
| act_high | input | CELLS | 1 = active-high pin, 0 = active-low pin |
| oe | input | CELLS | Output-enable term for each cell |
| pin_o | output | CELLS | Value driven toward the pin |
| pin_en | output | CELLS | Pin drive enable; low means tri-stated |
| fb | output | CELLS | Feedback returned to the array |

## Verification
The bench builds the block with `CELLS = 2`. This width lets a single vector place one registered cell next to one combinatorial cell, each with a different polarity, which exposes any crosstalk between cells. While the table is walked, preload holds the register pair at a fixed asymmetric value, so the registered-mode pin and feedback values can be predicted on every row. Directed steps then check clock-edge timing, priority between clear, preload and preset, and the clear that acts without a clock.

// File: rtl/pld_out_cell.sv
module pld_out_cell #(
  parameter int CELLS = 1
) (
  input  logic             clk,
  input  logic             pwr_init,
  input  logic             areset,
  input  logic             spreset,
  input  logic             preload_en,
  input  logic [CELLS-1:0] preload_val,
  input  logic [CELLS-1:0] sum,
  input  logic [CELLS-1:0] reg_mode,
  input  logic [CELLS-1:0] act_high,
  input  logic [CELLS-1:0] oe,
  output logic [CELLS-1:0] pin_o,
  output logic [CELLS-1:0] pin_en,
  output logic [CELLS-1:0] fb
);
  localparam logic [CELLS-1:0] ALL_SET = '1;
  localparam logic [CELLS-1:0] ALL_CLR = '0;

  logic             clr;
  logic [CELLS-1:0] q;
  logic [CELLS-1:0] src;

  assign clr = pwr_init | areset;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)             q <= ALL_CLR;
    else if (preload_en) q <= preload_val;
    else if (spreset)    q <= ALL_SET;
    else                 q <= sum;
  end

  assign src    = (reg_mode & q) | (~reg_mode & sum);
  assign pin_o  = src ^ ~act_high;
  assign pin_en = oe;
  assign fb     = (reg_mode & q) | (~reg_mode & pin_o);

  // R3
  clear_holds_chk: assert property (@(posedge clk) clr |-> q == ALL_CLR);

  // R6
  preset_sets_chk: assert property (@(posedge clk) disable iff (clr)
    (spreset && !preload_en) |=> q == ALL_SET);

  // R7
  preload_loads_chk: assert property (@(posedge clk) disable iff (clr)
    preload_en |=> q == $past(preload_val));

  // R5
  sum_capture_chk: assert property (@(posedge clk) disable iff (clr)
    (!spreset && !preload_en) |=> q == $past(sum));
endmodule

// File: tb/sim_pld_out_cell.sv
`timescale 1ns/1ps
module sim_pld_out_cell;
  localparam int CELLS = 2;
  localparam int NV = 8;

  // fields: reg_mode, act_high, sum, oe, exp pin, exp en, exp fb (2 bits each)
  localparam logic [13:0] VEC [NV] = '{
    {2'b00, 2'b11, 2'b01, 2'b11, 2'b01, 2'b11, 2'b01},
    {2'b00, 2'b00, 2'b01, 2'b11, 2'b10, 2'b11, 2'b10},
    {2'b00, 2'b10, 2'b11, 2'b01, 2'b10, 2'b01, 2'b10},
    {2'b00, 2'b01, 2'b00, 2'b00, 2'b10, 2'b00, 2'b10},
    {2'b11, 2'b11, 2'b00, 2'b11, 2'b10, 2'b11, 2'b10},
    {2'b11, 2'b00, 2'b11, 2'b11, 2'b01, 2'b11, 2'b10},
    {2'b01, 2'b10, 2'b11, 2'b10, 2'b11, 2'b10, 2'b10},
    {2'b10, 2'b01, 2'b00, 2'b01, 2'b00, 2'b01, 2'b10}
  };

  logic clk = 1'b0;
  logic pwr_init, areset, spreset, preload_en;
  logic [CELLS-1:0] preload_val, sum, reg_mode, act_high, oe;
  logic [CELLS-1:0] pin_o, pin_en, fb;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pld_out_cell #(.CELLS(CELLS)) u0 (
    .clk(clk), .pwr_init(pwr_init), .areset(areset), .spreset(spreset),
    .preload_en(preload_en), .preload_val(preload_val), .sum(sum),
    .reg_mode(reg_mode), .act_high(act_high), .oe(oe),
    .pin_o(pin_o), .pin_en(pin_en), .fb(fb)
  );

  task automatic chk(input string req, input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  initial begin
    pwr_init = 1'b1; areset = 1'b0; spreset = 1'b0; preload_en = 1'b0;
    preload_val = '0; sum = 2'b11; reg_mode = 2'b11; act_high = 2'b11; oe = 2'b11;
    #1;
    // R4 power-up init clears registers
    chk("R4 fb after init", fb, 2'b00);
    chk("R4 pin active-high", pin_o, 2'b00);
    act_high = 2'b00; #1;
    chk("R3 pin active-low after clear", pin_o, 2'b11);
    after_edge();
    // R8 clear dominates the edge
    chk("R8 clear held over edge", fb, 2'b00);

    @(negedge clk);
    pwr_init = 1'b0; preload_en = 1'b1; preload_val = 2'b10;
    after_edge();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {reg_mode, act_high, sum, oe} = VEC[i][13:6];
      #1;
      // R1 R2 R9 R10 R11
      chk($sformatf("R1/R2/R11 pin vec%0d", i), pin_o, VEC[i][5:4]);
      chk($sformatf("R9 en vec%0d", i), pin_en, VEC[i][3:2]);
      chk($sformatf("R10 fb vec%0d", i), fb, VEC[i][1:0]);
    end

    // R5 capture only on the edge
    @(negedge clk);
    preload_en = 1'b0; reg_mode = 2'b11; act_high = 2'b11; oe = 2'b00; sum = 2'b01;
    #1;
    chk("R5 pin before edge", pin_o, 2'b10);
    chk("R9 pin valued while disabled", pin_en, 2'b00);
    after_edge();
    chk("R5 pin after edge", pin_o, 2'b01);

    // R6 preset on next edge only
    @(negedge clk);
    spreset = 1'b1; sum = 2'b00; #1;
    chk("R6 not before edge", fb, 2'b01);
    after_edge();
    chk("R6 set after edge", fb, 2'b11);
    act_high = 2'b00; #1;
    chk("R10 fb ignores polarity", fb, 2'b11);
    chk("R2 inverted pin", pin_o, 2'b00);

    // R7 preload beats preset
    @(negedge clk);
    preload_en = 1'b1; preload_val = 2'b01;
    after_edge();
    chk("R7 preload over preset", fb, 2'b01);

    // R3 async clear without an edge
    @(negedge clk);
    preload_en = 1'b0;
    after_edge();
    chk("R6 set again", fb, 2'b11);
    @(negedge clk); #1;
    areset = 1'b1; #0.5;
    chk("R3 cleared without edge", fb, 2'b00);
    preload_en = 1'b1; preload_val = 2'b11;
    after_edge();
    chk("R8 clear beats preset and preload", fb, 2'b00);
    @(negedge clk);
    areset = 1'b0;
    after_edge();
    chk("R7 preload after clear released", fb, 2'b11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule